// File: doc/BRIEF.md
# Gated Quadrature Event Counter

This block is a 32-bit up/down counter of external events. It counts rising edges on a single phase input, with the direction taken from a control bit, or it decodes a two-phase quadrature signal at either one count per full quadrature cycle or one count per phase change. Two optional gating inputs shape the counting. A reset input clears the count. A start input allows or freezes the count. A chosen gate option can use neither, the reset input only, or both.

Configuration is a one-shot step. A define strobe latches the count type, the quadrature rate, the gate option and the active level of each gating input. After that the configuration is frozen until a stop strobe returns the block to the unconfigured state. During a run, an update strobe writes the run-time fields in a single cycle: enable, direction, an optional load of the current count and an optional load of the preset register. All four external inputs pass through a synchroniser. The block has no streaming data path, so every pin is a plain control or status signal, and no pin applies back-pressure.

Top module: `qenc_event_counter`

## Requirements
- R1: After reset, count_o and preset_o read 0, dir_o reads 1 (up), err_o reads 0 and configured_o reads 0.
- R2: A define_i strobe while unconfigured latches cfg_quad_i, cfg_rate_1x_i, cfg_rst_pol_i, cfg_start_pol_i and cfg_gate_i, and sets configured_o on the next edge. A define_i strobe while configured changes nothing. stop_i clears configured_o and the enable on the next edge and wins over define_i in the same cycle.
- R3: While unconfigured, input events and the reset input never change the count. Only a load by update strobe can change it.
- R4: When cfg_quad=0, each rising edge on phase_a_i counts +1 if the direction is 1 and -1 if it is 0. The direction is the value written by upd_dir_i. The count moves on the third clock edge after the pin changes.
- R5: When cfg_quad=1 and cfg_rate_1x=0, every change of exactly one phase counts. The sequence (A,B) 00→10→11→01→00 counts up and the reverse sequence counts down.
- R6: When cfg_quad=1 and cfg_rate_1x=1, the block counts only a change of A while B is 0: up when A rises and down when A falls. This gives one count per quadrature cycle.
- R7: A cycle in which both synchronised phases change leaves the count unchanged. In quadrature mode it raises err_o for exactly one cycle, aligned with the cycle in which a legal step would have counted.
- R8: While the reset input is active and the start input is active or unused, the count is cleared to 0 and held at 0, and events are ignored until reset is released.
- R9: While the start input is in use and inactive, the count holds. Events and the reset input are ignored.
- R10: If the start input becomes active while the reset input is still active, the count is cleared.
- R11: cfg_rst_pol / cfg_start_pol = 0 makes that input active high, and 1 makes it active low.
- R12: upd_i writes the enable (upd_en_i), the direction (upd_dir_i) and, when their flags are set, the count (cv_data_i) and the preset (pv_data_i), all on the next edge. A count load wins over a counted event, and an active clear wins over a load.
- R13: In quadrature mode, upd_dir_i only sets the initial value of dir_o. Each counted step then sets dir_o to the decoded direction.
- R14: cfg_gate = 00 ignores both gating inputs. 01 uses the reset input only. 10 or 11 uses both the reset and start inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| define_i | input | 1 | One-shot configuration strobe |
| stop_i | input | 1 | Return to unconfigured state |
| cfg_quad_i | input | 1 | 0 single-phase, 1 quadrature |
| cfg_rate_1x_i | input | 1 | Quadrature rate: 0 every phase change, 1 once per cycle |
| cfg_rst_pol_i | input | 1 | Reset input level: 0 active high, 1 active low |
| cfg_start_pol_i | input | 1 | Start input level: 0 active high, 1 active low |
| cfg_gate_i | input | 2 | Gating inputs in use (see R14) |
| upd_i | input | 1 | Run-time update strobe |
| upd_en_i | input | 1 | Enable value written by upd_i |
| upd_dir_i | input | 1 | Direction written by upd_i (1 = up) |
| upd_load_cv_i | input | 1 | Load count from cv_data_i |
| cv_data_i | input | CNT_W | Count load value |
| upd_load_pv_i | input | 1 | Load preset from pv_data_i |
| pv_data_i | input | CNT_W | Preset load value |
| phase_a_i | input | 1 | Event input / quadrature phase A (asynchronous) |
| phase_b_i | input | 1 | Quadrature phase B (asynchronous) |
| rst_in_i | input | 1 | External count reset (asynchronous) |
| start_in_i | input | 1 | External count start (asynchronous) |
| count_o | output | CNT_W | Current count |
| preset_o | output | CNT_W | Preset register |
| dir_o | output | 1 | Current direction (1 = up) |
| err_o | output | 1 | Illegal quadrature transition pulse |
| configured_o | output | 1 | Configuration latched |

## Verification
The assertions assume that define_i, stop_i, upd_i and the update fields are synchronous to clk and that the block is reset at start-up. The phase, reset and start pins may change at any time, because the assertions only look at their synchronised values. The stimulus changes every input just after a falling clock edge and holds each phase state for at least two cycles, so each legal step is seen once. It makes both phases jump together only to exercise R7. Gating inputs are held for several cycles, so the synchroniser delay never splits a clear from a load.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    GATE_NONE  = 2'b00,
    GATE_RST   = 2'b01,
    GATE_BOTH  = 2'b10,
    GATE_BOTH2 = 2'b11
  } gate_e;

  typedef struct packed {
    logic  quad;
    logic  rate_1x;
    logic  rst_pol;
    logic  start_pol;
    gate_e gate;
  } cfg_t;

  localparam int unsigned SYNC_W = 4;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  logic quad,
  input  logic rate_1x,
  output logic evt,
  output logic evt_up,
  output logic illegal
);
  logic a_d, b_d;
  logic ch_a, ch_b, step_all, step_one;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_d <= 1'b0;
      b_d <= 1'b0;
    end else begin
      a_d <= a;
      b_d <= b;
    end

  assign ch_a     = a ^ a_d;
  assign ch_b     = b ^ b_d;
  assign step_all = ch_a ^ ch_b;
  assign step_one = ch_a & ~ch_b & ~b;

  always_comb begin
    if (quad) begin
      evt     = rate_1x ? step_one : step_all;
      illegal = ch_a & ch_b;
    end else begin
      evt     = a & ~a_d;
      illegal = 1'b0;
    end
    evt_up = a ^ b_d;
  end
endmodule

// File: rtl/qenc_count_core.sv
module qenc_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             pv_load,
  input  logic [CNT_W-1:0] pv_val,
  input  logic             step,
  input  logic             quad,
  input  logic             step_up,
  input  logic             dir_wr,
  input  logic             dir_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] preset,
  output logic             dir
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic go_up;

  assign go_up = quad ? step_up : dir;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (step) begin
      count <= go_up ? count + ONE : count - ONE;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               dir <= 1'b1;
    else if (dir_wr)          dir <= dir_val;
    else if (step && quad)    dir <= step_up;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       preset <= '0;
    else if (pv_load) preset <= pv_val;
endmodule

// File: rtl/qenc_event_counter.sv
module qenc_event_counter
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             define_i,
  input  logic             stop_i,
  input  logic             cfg_quad_i,
  input  logic             cfg_rate_1x_i,
  input  logic             cfg_rst_pol_i,
  input  logic             cfg_start_pol_i,
  input  logic [1:0]       cfg_gate_i,
  input  logic             upd_i,
  input  logic             upd_en_i,
  input  logic             upd_dir_i,
  input  logic             upd_load_cv_i,
  input  logic [CNT_W-1:0] cv_data_i,
  input  logic             upd_load_pv_i,
  input  logic [CNT_W-1:0] pv_data_i,
  input  logic             phase_a_i,
  input  logic             phase_b_i,
  input  logic             rst_in_i,
  input  logic             start_in_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] preset_o,
  output logic             dir_o,
  output logic             err_o,
  output logic             configured_o
);
  cfg_t             cfg_q;
  cfg_t             cfg_new;
  logic             configured_q;
  logic             en_q;
  logic             err_q;
  logic [SYNC_W-1:0] sy;
  logic             evt, evt_up, illegal;
  logic             rst_act, start_act, clear, step_go;

  qenc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({start_in_i, rst_in_i, phase_b_i, phase_a_i}),
    .q     (sy)
  );

  qenc_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .a       (sy[0]),
    .b       (sy[1]),
    .quad    (cfg_q.quad),
    .rate_1x (cfg_q.rate_1x),
    .evt     (evt),
    .evt_up  (evt_up),
    .illegal (illegal)
  );

  assign cfg_new = '{quad:      cfg_quad_i,
                     rate_1x:   cfg_rate_1x_i,
                     rst_pol:   cfg_rst_pol_i,
                     start_pol: cfg_start_pol_i,
                     gate:      gate_e'(cfg_gate_i)};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q        <= '0;
      configured_q <= 1'b0;
    end else if (stop_i) begin
      cfg_q        <= '0;
      configured_q <= 1'b0;
    end else if (define_i && !configured_q) begin
      cfg_q        <= cfg_new;
      configured_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      en_q <= 1'b0;
    else if (stop_i) en_q <= 1'b0;
    else if (upd_i)  en_q <= upd_en_i;

  assign rst_act   = configured_q && (cfg_q.gate != GATE_NONE) && (sy[2] ^ cfg_q.rst_pol);
  assign start_act = cfg_q.gate[1] ? (sy[3] ^ cfg_q.start_pol) : 1'b1;
  assign clear     = configured_q && start_act && rst_act;
  assign step_go   = configured_q && en_q && start_act && evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= configured_q && illegal;

  qenc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .load     (upd_i && upd_load_cv_i),
    .load_val (cv_data_i),
    .pv_load  (upd_i && upd_load_pv_i),
    .pv_val   (pv_data_i),
    .step     (step_go),
    .quad     (cfg_q.quad),
    .step_up  (evt_up),
    .dir_wr   (upd_i),
    .dir_val  (upd_dir_i),
    .count    (count_o),
    .preset   (preset_o),
    .dir      (dir_o)
  );

  assign err_o        = err_q;
  assign configured_o = configured_q;
endmodule

// File: rtl/qenc_event_counter_chk.sv
module qenc_event_counter_chk
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             define_i,
  input logic             stop_i,
  input logic             upd_i,
  input logic             upd_load_cv_i,
  input logic [CNT_W-1:0] cv_data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             err_o,
  input logic             configured_o,
  input cfg_t             cfg,
  input logic             rst_act,
  input logic             start_act
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_stop_unconfig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !configured_o);

  assert_define_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_o && define_i && !stop_i) |=> $stable(cfg));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!configured_o && !(upd_i && upd_load_cv_i)) |=> $stable(count_o));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_o && rst_act && start_act) |=> (count_o == '0));

  assert_start_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_o && !start_act && !(upd_i && upd_load_cv_i)) |=> $stable(count_o));

  assert_err_quad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(configured_o && cfg.quad));

  assert_load_value_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && upd_load_cv_i && !(configured_o && rst_act && start_act))
      |=> (count_o == $past(cv_data_i)));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(upd_i && upd_load_cv_i) && !(configured_o && rst_act && start_act))
      |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) + ONE) ||
           (count_o == $past(count_o) - ONE)));
endmodule

bind qenc_event_counter qenc_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .define_i      (define_i),
  .stop_i        (stop_i),
  .upd_i         (upd_i),
  .upd_load_cv_i (upd_load_cv_i),
  .cv_data_i     (cv_data_i),
  .count_o       (count_o),
  .err_o         (err_o),
  .configured_o  (configured_o),
  .cfg           (cfg_q),
  .rst_act       (rst_act),
  .start_act     (start_act)
);

// File: tb/qenc_event_counter_test.sv
`timescale 1ns/1ps
module qenc_event_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        define_i = 0, stop_i = 0;
  logic        cfg_quad_i = 0, cfg_rate_1x_i = 0, cfg_rst_pol_i = 0, cfg_start_pol_i = 0;
  logic [1:0]  cfg_gate_i = 0;
  logic        upd_i = 0, upd_en_i = 0, upd_dir_i = 0, upd_load_cv_i = 0, upd_load_pv_i = 0;
  logic [31:0] cv_data_i = 0, pv_data_i = 0;
  logic        phase_a_i = 0, phase_b_i = 0, rst_in_i = 0, start_in_i = 0;
  logic [31:0] count_o, preset_o;
  logic        dir_o, err_o, configured_o;

  int    checks = 0, failures = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #5 clk = ~clk;

  qenc_event_counter uut (.*);

  // behavioural reference model
  bit [3:0]  m_s1, m_s2;
  bit        m_pa, m_pb;
  bit        m_conf, m_en, m_dir, m_err;
  bit        m_quad, m_r1x, m_rpol, m_spol;
  bit [1:0]  m_gate;
  bit [31:0] m_cnt, m_pv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pa = 0; m_pb = 0; m_conf = 0; m_en = 0; m_dir = 1; m_err = 0;
      m_quad = 0; m_r1x = 0; m_rpol = 0; m_spol = 0; m_gate = 0; m_cnt = 0; m_pv = 0;
    end else begin
      bit a, b, ca, cb, ev, up, bad, ra, sa, go;
      a = m_s2[0]; b = m_s2[1];
      ca = (a != m_pa); cb = (b != m_pb);
      if (m_quad) begin
        bad = ca && cb;
        ev  = m_r1x ? (ca && !cb && !b) : (ca != cb);
        up  = a ^ m_pb;
      end else begin
        bad = 0; ev = a && !m_pa; up = m_dir;
      end
      ra = m_conf && (m_gate != 0) && (m_s2[2] ^ m_rpol);
      sa = (m_gate >= 2) ? (m_s2[3] ^ m_spol) : 1'b1;
      go = m_conf && m_en && sa && ev;
      if (m_conf && sa && ra)          m_cnt = 0;
      else if (upd_i && upd_load_cv_i) m_cnt = cv_data_i;
      else if (go)                     m_cnt = up ? m_cnt + 1 : m_cnt - 1;
      if (upd_i)             m_dir = upd_dir_i;
      else if (go && m_quad) m_dir = up;
      if (upd_i && upd_load_pv_i) m_pv = pv_data_i;
      m_err = m_conf && m_quad && bad;
      if (stop_i)     m_en = 0;
      else if (upd_i) m_en = upd_en_i;
      if (stop_i) begin
        m_conf = 0; m_quad = 0; m_r1x = 0; m_rpol = 0; m_spol = 0; m_gate = 0;
      end else if (define_i && !m_conf) begin
        m_conf = 1; m_quad = cfg_quad_i; m_r1x = cfg_rate_1x_i;
        m_rpol = cfg_rst_pol_i; m_spol = cfg_start_pol_i; m_gate = cfg_gate_i;
      end
      m_pa = a; m_pb = b;
      m_s2 = m_s1;
      m_s1 = {start_in_i, rst_in_i, phase_b_i, phase_a_i};
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(cur_req, "count model", count_o, m_cnt);
    chk(cur_req, "preset model", preset_o, m_pv);
    chk(cur_req, "dir model", {31'b0, dir_o}, {31'b0, m_dir});
    chk(cur_req, "err model", {31'b0, err_o}, {31'b0, m_err});
    chk(cur_req, "configured model", {31'b0, configured_o}, {31'b0, m_conf});
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ab(logic a, logic b);
    phase_a_i = a; phase_b_i = b; tick(2);
  endtask

  task automatic pulse_a(int n);
    for (int i = 0; i < n; i++) begin
      set_ab(1, 0); set_ab(0, 0);
    end
  endtask

  task automatic fwd_cycle();
    set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
  endtask

  task automatic do_define(logic q, logic r1, logic rp, logic sp, logic [1:0] g);
    cfg_quad_i = q; cfg_rate_1x_i = r1; cfg_rst_pol_i = rp; cfg_start_pol_i = sp; cfg_gate_i = g;
    define_i = 1; tick(1); define_i = 0;
  endtask

  task automatic do_upd(logic en, logic dir, logic lcv, logic [31:0] cv, logic lpv, logic [31:0] pv);
    upd_en_i = en; upd_dir_i = dir; upd_load_cv_i = lcv; cv_data_i = cv;
    upd_load_pv_i = lpv; pv_data_i = pv;
    upd_i = 1; tick(1); upd_i = 0; upd_load_cv_i = 0; upd_load_pv_i = 0;
  endtask

  task automatic do_stop();
    stop_i = 1; tick(1); stop_i = 0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(1);
    cur_req = "R1";
    chk("R1", "count after reset", count_o, 0);
    chk("R1", "configured after reset", {31'b0, configured_o}, 0);
    chk("R1", "dir after reset", {31'b0, dir_o}, 1);

    cur_req = "R3";
    do_upd(1, 1, 0, 0, 0, 0);
    pulse_a(3); rst_in_i = 1; tick(4); rst_in_i = 0; tick(3);
    chk("R3", "count while unconfigured", count_o, 0);

    cur_req = "R4";
    do_define(0, 0, 0, 0, 2'b00);
    chk("R2", "configured after define", {31'b0, configured_o}, 1);
    pulse_a(5); tick(3);
    chk("R4", "single-phase up", count_o, 5);
    do_upd(1, 0, 0, 0, 0, 0);
    pulse_a(2); tick(3);
    chk("R4", "single-phase down", count_o, 3);

    cur_req = "R14";
    rst_in_i = 1; tick(4); pulse_a(1); tick(3);
    chk("R14", "gate none ignores reset", count_o, 2);
    rst_in_i = 0; tick(3);

    cur_req = "R2";
    do_define(1, 0, 0, 0, 2'b10);
    pulse_a(1); tick(3);
    chk("R2", "second define rejected", count_o, 1);

    cur_req = "R12";
    do_upd(1, 1, 1, 100, 1, 32'hABCD);
    chk("R12", "count load", count_o, 100);
    chk("R12", "preset load", preset_o, 32'hABCD);
    phase_a_i = 1; tick(2);
    do_upd(1, 1, 1, 50, 0, 0);
    phase_a_i = 0; tick(3);
    chk("R12", "load beats event", count_o, 50);

    cur_req = "R2";
    do_stop();
    chk("R2", "stop unconfigures", {31'b0, configured_o}, 0);
    pulse_a(2); tick(3);
    chk("R2", "no count after stop", count_o, 50);

    cur_req = "R5";
    do_define(1, 0, 0, 0, 2'b10);
    start_in_i = 1;
    do_upd(1, 1, 1, 0, 0, 0);
    tick(2);
    fwd_cycle(); tick(3);
    chk("R5", "4x forward", count_o, 4);
    chk("R13", "dir up", {31'b0, dir_o}, 1);
    set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0); tick(3);
    chk("R5", "4x reverse", count_o, 0);
    chk("R13", "dir down", {31'b0, dir_o}, 0);
    set_ab(1, 0); set_ab(1, 1); tick(3);
    chk("R5", "4x two steps", count_o, 2);

    cur_req = "R13";
    do_upd(1, 0, 0, 0, 0, 0);
    chk("R13", "initial dir written", {31'b0, dir_o}, 0);
    set_ab(0, 1); tick(3);
    chk("R13", "dir follows motion", {31'b0, dir_o}, 1);
    chk("R13", "count after step", count_o, 3);

    cur_req = "R7";
    set_ab(1, 0); tick(1);
    chk("R7", "err pulse high", {31'b0, err_o}, 1);
    tick(1);
    chk("R7", "err pulse ends", {31'b0, err_o}, 0);
    chk("R7", "illegal ignored", count_o, 3);
    set_ab(0, 0); tick(3);
    chk("R7", "legal after illegal", count_o, 2);

    cur_req = "R9";
    start_in_i = 0; tick(3);
    set_ab(1, 0); set_ab(1, 1); tick(3);
    chk("R9", "events ignored", count_o, 2);
    rst_in_i = 1; tick(4);
    chk("R9", "reset ignored", count_o, 2);

    cur_req = "R10";
    start_in_i = 1; tick(4);
    chk("R10", "start under reset clears", count_o, 0);

    cur_req = "R8";
    set_ab(0, 1); set_ab(0, 0); tick(3);
    chk("R8", "held at zero", count_o, 0);
    rst_in_i = 0; tick(3);
    set_ab(1, 0); tick(3);
    chk("R8", "counts after release", count_o, 1);

    cur_req = "R6";
    do_stop();
    rst_in_i = 1; set_ab(0, 0); tick(3);
    do_define(1, 1, 1, 0, 2'b01);
    do_upd(1, 1, 1, 0, 0, 0);
    fwd_cycle(); fwd_cycle(); tick(3);
    chk("R6", "1x forward", count_o, 2);
    set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0); tick(3);
    chk("R6", "1x reverse", count_o, 1);

    cur_req = "R11";
    rst_in_i = 0; tick(4);
    chk("R11", "active-low reset clears", count_o, 0);
    fwd_cycle(); tick(3);
    chk("R11", "held under low reset", count_o, 0);
    rst_in_i = 1; tick(3);
    fwd_cycle(); tick(3);
    chk("R11", "counts after high", count_o, 1);

    do_stop();
    start_in_i = 1; rst_in_i = 0;
    do_define(1, 0, 0, 1, 2'b10);
    do_upd(1, 1, 1, 7, 0, 0);
    tick(3);
    set_ab(1, 0); set_ab(1, 1); tick(3);
    chk("R11", "start active-low inactive", count_o, 7);
    start_in_i = 0; tick(3);
    set_ab(0, 1); set_ab(0, 0); tick(3);
    chk("R11", "start active-low active", count_o, 9);

    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end
endmodule